// File: doc/BRIEF.md
# Six-Pin Bidirectional Port with Direction Control

This block is a six-pin general purpose I/O port that sits on a small synchronous register bus. Software sees two eight-bit registers: a pin-level register and a direction register. Each pin has an output latch, an output enable and an input path. On the pin side there are three separate vectors, for input levels, output values and output enables. The pin inputs pass through a two-flop synchronizer. A read of the pin-level register returns those synchronized levels. It does not return the latch contents.

Pin 3 can only be an input. Its direction bit always reads as 1 and it never drives. Per-pin analog-select inputs force the read-back of their pins to 0 but leave the drivers alone. A reset-pin configuration input forces pin 3 to read as 0. A bit set/clear command does the read-modify-write inside the block. It merges one changed bit with the synchronized pin levels and loads the result into the output latch.

Top module: `gpio6_port`

## Requirements
- R1: Address 0 selects the pin-level register and address 1 selects the direction register. In both registers, bits 7 and 6 always read as 0.
- R2: A direction bit of 0 sets `pin_oe` for that pin and drives the latch value on `pin_out`. A direction bit of 1 clears `pin_oe`.
- R3: Pin 3 is input only. Its direction bit reads as 1 and `pin_oe[3]` stays 0 whatever value is written.
- R4: A read of address 0 returns the pin levels sampled two clocks earlier through the synchronizer. It never returns the output latch.
- R5: A full write (`wr_en` with address 0) loads `wdata[5:0]` into the output latch on the next edge. A direction write (address 1) loads the direction bits on the next edge.
- R6: A pin whose `ana_sel` bit is 1 reads as 0 at address 0. Its direction bit still controls its driver.
- R7: When `mclr_en` is 1, pin 3 reads as 0 at address 0.
- R8: After reset, the direction register reads 0x08, so pins 0, 1, 2, 4 and 5 drive and pin 3 does not.
- R9: A bit command (`bit_en`, with `bit_sel` naming the pin and `bit_val` giving the new value) loads the output latch with the readable pin levels. The selected bit is replaced by `bit_val`. An output pin that is held low outside the block therefore latches 0 when a different bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Register select: 0 pin levels, 1 direction |
| wr_en | input | 1 | Full register write strobe |
| wdata | input | 8 | Write data |
| bit_en | input | 1 | Bit set/clear command strobe, acting on the latch |
| bit_sel | input | 3 | Pin index for the bit command |
| bit_val | input | 1 | New value for the selected bit |
| rdata | output | 8 | Read data for the selected register |
| ana_sel | input | 6 | Per-pin analog select |
| mclr_en | input | 1 | Pin 3 used as reset pin |
| pin_in | input | 6 | Pin levels from the pads |
| pin_out | output | 6 | Output latch values toward the pads |
| pin_oe | output | 6 | Per-pin output enables |

## Verification
The hardest case to reach is a bit command that overwrites a latch value the pin itself contradicts. This needs an output pin whose latch holds 1 while the outside world pulls it low. The bench gets there in three steps. It writes all ones to the latch, forces the matching `pin_in` bit low, and waits two clocks so the synchronizer settles. It then issues a set on a different pin and checks that `pin_out` has dropped the contradicted bit. Analog and reset-pin masking are checked the same way: the pins are held at 1 while `ana_sel` and `mclr_en` change.

// File: rtl/gpio6_port.sv
module gpio6_port #(
  parameter int W = 6,
  parameter int DW = 8,
  parameter int IN_ONLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          bit_en,
  input  logic [2:0]    bit_sel,
  input  logic          bit_val,
  output logic [DW-1:0] rdata,
  input  logic [W-1:0]  ana_sel,
  input  logic          mclr_en,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe
);
  localparam logic [W-1:0] FIXED = W'(1) << IN_ONLY;

  logic [W-1:0] sync1, sync2, latch_q, dir_q, mask, levels, dir_rd, bit_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end

  assign mask     = ~ana_sel & ~(mclr_en ? FIXED : '0);
  assign levels   = sync2 & mask;
  assign dir_rd   = dir_q | FIXED;
  assign bit_mask = W'(1) << bit_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q   <= FIXED;
      latch_q <= '0;
    end else begin
      if (wr_en && addr)
        dir_q <= wdata[W-1:0] | FIXED;
      if (wr_en && !addr)
        latch_q <= wdata[W-1:0];
      else if (bit_en)
        latch_q <= bit_val ? (levels | bit_mask) : (levels & ~bit_mask);
    end

  assign rdata   = addr ? DW'(dir_rd) : DW'(levels);
  assign pin_out = latch_q;
  assign pin_oe  = ~dir_rd;

  // R1
  upper_zero_chk: assert property (@(posedge clk) rdata[DW-1:W] == '0);
  // R3
  in_only_chk: assert property (@(posedge clk) disable iff (!rst_n) !pin_oe[IN_ONLY]);
  // R7
  mclr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr_en && !addr) |-> !rdata[IN_ONLY]);
  // R6
  ana_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr |-> ((rdata[W-1:0] & ana_sel) == '0));
  // R5
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr) |=> pin_out == $past(wdata[W-1:0]));
  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr) |=> pin_oe == (~$past(wdata[W-1:0]) & ~FIXED));
endmodule

// File: tb/gpio6_port_tb.sv
module gpio6_port_tb;
  logic clk = 0, rst_n = 0, addr = 0, wr_en = 0, bit_en = 0, bit_val = 0, mclr_en = 0;
  logic [7:0] wdata = 0;
  logic [2:0] bit_sel = 0;
  logic [5:0] ana_sel = 0, pin_in = 0;
  logic [7:0] rdata;
  logic [5:0] pin_out, pin_oe;
  int checks = 0, errors = 0;

  gpio6_port u_dut (.clk, .rst_n, .addr, .wr_en, .wdata, .bit_en, .bit_sel, .bit_val,
    .rdata, .ana_sel, .mclr_en, .pin_in, .pin_out, .pin_oe);

  always #10 clk = ~clk;

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #5; endtask

  // direction write value, expected oe, expected dir read
  localparam logic [7:0] VEC [4][3] = '{
    '{8'hFF, 8'h00, 8'h3F},
    '{8'h00, 8'h37, 8'h08},
    '{8'h15, 8'h22, 8'h1D},
    '{8'hC2, 8'h35, 8'h0A}};

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    #25 rst_n = 1; #5;
    addr = 1; #1;
    chk("R8 dir reset", rdata, 8'h08);
    chk("R8 oe reset", {2'b0, pin_oe}, 8'h37);
    for (int i = 0; i < 4; i++) begin
      addr = 1; wdata = VEC[i][0]; wr_en = 1; tick(); wr_en = 0;
      chk("R2 oe", {2'b0, pin_oe}, VEC[i][1]);
      chk("R3 dir read", rdata, VEC[i][2]);
    end
    addr = 1; wdata = 8'h00; wr_en = 1; tick(); wr_en = 0;
    addr = 0; wdata = 8'hA5; wr_en = 1; tick(); wr_en = 0;
    chk("R5 latch", {2'b0, pin_out}, 8'h25);
    pin_in = 6'h2A; tick();
    chk("R4 one clock", rdata, 8'h00);
    tick();
    chk("R4 two clocks", rdata, 8'h2A);
    chk("R1 upper bits", {rdata[7:6], 6'b0}, 8'h00);
    pin_in = 6'h3F; tick(); tick();
    chk("R4 full", rdata, 8'h3F);
    ana_sel = 6'h05; #1;
    chk("R6 analog masked", rdata, 8'h3A);
    chk("R6 oe kept", {2'b0, pin_oe}, 8'h37);
    ana_sel = 0; mclr_en = 1; #1;
    chk("R7 mclr", rdata, 8'h37);
    mclr_en = 0;
    wdata = 8'h3F; wr_en = 1; tick(); wr_en = 0;
    pin_in = 6'h3E; tick(); tick();
    bit_sel = 4; bit_val = 1; bit_en = 1; tick(); bit_en = 0;
    chk("R9 held-low cleared", {2'b0, pin_out}, 8'h3E);
    bit_sel = 5; bit_val = 0; bit_en = 1; tick(); bit_en = 0;
    chk("R9 bit clear", {2'b0, pin_out}, 8'h1E);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule